// File: doc/BRIEF.md
# Thread Block Admission Controller

This block decides whether a new thread block may be placed on a multiprocessor, given what is still free there. Three limits are checked at once: the number of resident blocks, the number of resident threads, and a pool of registers that is split among resident blocks on demand. A request carries a thread count and a registers-per-thread count. The block needs their product in registers, taken as one contiguous range.

A request that passes every limit is granted. The grant names the lowest free block slot and the lowest base address at which a gap of the needed size exists. The register allocator is first-fit. Gaps left by released blocks join with their free neighbours, so a later, larger request can reuse them. A release names a slot, and that slot's threads and registers are returned at the next clock edge. Blocks may arrive and leave in any order.

A request and a release may occur in the same cycle. The request is then judged against the state before the release. The request handshake is valid/ready, and each handshake produces a single-cycle response.

Top module: `blk_admit`

## Requirements
- R1: After reset the resident block count and resident thread count are 0, the free register count is 8192, resp_valid is 0, and req_ready is 1 from the first clock edge after reset is released.
- R2: A request with thread count 0, thread count above 512, or registers-per-thread 0 gets resp_code 2 (invalid), and the resident counts and free register count are unchanged.
- R3: A request that fits every limit gets resp_code 0 (accept) and resp_slot equal to the lowest-numbered vacant slot. The resident blocks, threads and free registers reflect the new block in the cycle after the handshake.
- R4: With 8 blocks resident, any valid request gets resp_code 1 (full).
- R5: A valid request that would bring resident threads above 768 gets resp_code 1 (full).
- R6: A block needs thread_count x regs_per_thread registers as one contiguous range. resp_base is the lowest address that starts a free gap at least that large inside the 8192-entry pool. If no such gap exists, the request gets resp_code 1 (full), even when the total free count would be enough.
- R7: The register ranges of any two resident blocks never overlap, and every range lies inside the pool.
- R8: A release of an occupied slot returns its threads, registers and slot, visible in the next cycle. Released ranges merge with adjacent free ranges for later first-fit placement. A release of a vacant slot has no effect.
- R9: resp_valid is 1 for exactly the cycle after each cycle with req_valid and req_ready both 1, and is 0 otherwise.
- R10: When a request and a release occur in the same cycle, the request is judged on the state before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Admission request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_threads | input | 11 | Threads in the requested block |
| req_rpt | input | 8 | Registers needed per thread |
| rel_valid | input | 1 | Release of a block this cycle |
| rel_slot | input | 3 | Slot of the block being released |
| resp_valid | output | 1 | Response present (one cycle) |
| resp_code | output | 2 | 0 accept, 1 full, 2 invalid |
| resp_slot | output | 3 | Granted slot (0 unless accepted) |
| resp_base | output | 14 | Granted register base (0 unless accepted) |
| resident_blocks | output | 4 | Blocks now resident |
| resident_threads | output | 10 | Threads now resident |
| free_regs | output | 14 | Registers now unallocated |

## Verification
A request handshake at one clock edge produces its response fields, and all three resident counts, in the cycle that follows that edge. A release becomes visible in the same cycle. The bench drives each operation at a falling edge, lets one rising edge pass, and compares every output at the next falling edge against a bench model. The model sorts the resident ranges by base and walks the gaps between them. Because of this timing, a request paired with a release is judged against the model state taken before either is applied.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;

  typedef enum logic [1:0] {
    RESP_ACCEPT  = 2'd0,
    RESP_FULL    = 2'd1,
    RESP_INVALID = 2'd2
  } resp_code_e;

  // registers a block asks for
  function automatic int unsigned reg_demand(int unsigned thr, int unsigned rpt);
    return thr * rpt;
  endfunction

  // shape rule: at least one thread, at most tmax, and a nonzero per-thread need
  function automatic logic shape_ok(int unsigned thr, int unsigned rpt, int unsigned tmax);
    return (thr >= 1) && (thr <= tmax) && (rpt >= 1);
  endfunction

endpackage

// File: rtl/blk_slot_pick.sv
module blk_slot_pick #(
  parameter int N  = 8,
  parameter int SW = 3
) (
  input  logic [N-1:0]  busy,
  output logic          any_free,
  output logic [SW-1:0] idx
);
  always_comb begin
    any_free = 1'b0;
    idx      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        idx      = SW'(i);
      end
    end
  end
endmodule

// File: rtl/blk_range_fit.sv
module blk_range_fit #(
  parameter int N    = 8,
  parameter int AW   = 14,
  parameter int POOL = 8192,
  localparam int EW  = AW + 1
) (
  input  logic [N-1:0]         busy,
  input  logic [N-1:0][AW-1:0] base,
  input  logic [N-1:0][AW-1:0] size,
  input  logic [EW-1:0]        need,
  output logic                 fit,
  output logic [AW-1:0]        fit_base
);
  // candidate starts: address 0 and the end of every resident range
  logic [N:0][EW-1:0] cand;
  logic [N:0]         cand_ok;

  for (genvar k = 0; k <= N; k++) begin : g_cand
    logic live;
    logic clear;
    if (k == 0) begin : g_origin
      assign cand[k] = '0;
      assign live    = 1'b1;
    end else begin : g_after
      assign cand[k] = EW'(base[k-1]) + EW'(size[k-1]);
      assign live    = busy[k-1];
    end
    always_comb begin
      clear = live && ((cand[k] + need) <= EW'(POOL));
      for (int j = 0; j < N; j++) begin
        if (busy[j] &&
            !(((cand[k] + need) <= EW'(base[j])) ||
              (cand[k] >= (EW'(base[j]) + EW'(size[j])))))
          clear = 1'b0;
      end
    end
    assign cand_ok[k] = clear;
  end

  logic [EW-1:0] best;
  always_comb begin
    fit  = 1'b0;
    best = '0;
    for (int k = 0; k <= N; k++) begin
      if (cand_ok[k] && (!fit || cand[k] < best)) begin
        fit  = 1'b1;
        best = cand[k];
      end
    end
    fit_base = AW'(best);
  end
endmodule

// File: rtl/blk_admit.sv
module blk_admit
  import blk_admit_pkg::*;
#(
  parameter int MAX_BLOCKS  = 8,
  parameter int MAX_THREADS = 768,
  parameter int REG_POOL    = 8192,
  parameter int BLK_THR_MAX = 512,
  parameter int RPT_W       = 8,
  localparam int SW   = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
  localparam int BW   = $clog2(MAX_BLOCKS + 1),
  localparam int TRW  = $clog2(BLK_THR_MAX) + 2,
  localparam int TW   = $clog2(MAX_THREADS + 1),
  localparam int AW   = $clog2(REG_POOL + 1),
  localparam int EW   = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [TRW-1:0] req_threads,
  input  logic [RPT_W-1:0] req_rpt,
  input  logic           rel_valid,
  input  logic [SW-1:0]  rel_slot,
  output logic           resp_valid,
  output logic [1:0]     resp_code,
  output logic [SW-1:0]  resp_slot,
  output logic [AW-1:0]  resp_base,
  output logic [BW-1:0]  resident_blocks,
  output logic [TW-1:0]  resident_threads,
  output logic [AW-1:0]  free_regs
);
  // per-slot bookkeeping of resident blocks
  logic [MAX_BLOCKS-1:0]         occ;
  logic [MAX_BLOCKS-1:0][TW-1:0] thr_of;
  logic [MAX_BLOCKS-1:0][AW-1:0] base_of;
  logic [MAX_BLOCKS-1:0][AW-1:0] size_of;
  logic [AW-1:0]                 used_regs;

  // named internal events
  logic          req_fire, shape_good, thr_room, slot_free, reg_fit;
  logic          grant, reject_full, reject_invalid, rel_fire;
  logic [SW-1:0] pick_slot;
  logic [AW-1:0] pick_base;
  logic [EW-1:0] need_w;
  int unsigned   need32;

  assign req_fire   = req_valid && req_ready;
  assign shape_good = shape_ok(32'(req_threads), 32'(req_rpt), BLK_THR_MAX);
  assign need32     = reg_demand(32'(req_threads), 32'(req_rpt));
  assign need_w     = (need32 > REG_POOL) ? EW'(REG_POOL + 1) : EW'(need32);
  assign thr_room   = (32'(resident_threads) + 32'(req_threads)) <= MAX_THREADS;

  blk_slot_pick #(.N(MAX_BLOCKS), .SW(SW)) u_slot (
    .busy     (occ),
    .any_free (slot_free),
    .idx      (pick_slot)
  );

  blk_range_fit #(.N(MAX_BLOCKS), .AW(AW), .POOL(REG_POOL)) u_fit (
    .busy     (occ),
    .base     (base_of),
    .size     (size_of),
    .need     (need_w),
    .fit      (reg_fit),
    .fit_base (pick_base)
  );

  assign reject_invalid = req_fire && !shape_good;
  assign grant          = req_fire && shape_good && slot_free && thr_room && reg_fit;
  assign reject_full    = req_fire && shape_good && !grant;
  assign rel_fire       = rel_valid && occ[rel_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ready        <= 1'b0;
      resp_valid       <= 1'b0;
      resp_code        <= RESP_ACCEPT;
      resp_slot        <= '0;
      resp_base        <= '0;
      occ              <= '0;
      thr_of           <= '0;
      base_of          <= '0;
      size_of          <= '0;
      resident_blocks  <= '0;
      resident_threads <= '0;
      used_regs        <= '0;
    end else begin
      req_ready  <= 1'b1;
      resp_valid <= req_fire;
      resp_slot  <= grant ? pick_slot : '0;
      resp_base  <= grant ? pick_base : '0;
      if (reject_invalid)   resp_code <= RESP_INVALID;
      else if (reject_full) resp_code <= RESP_FULL;
      else                  resp_code <= RESP_ACCEPT;

      for (int i = 0; i < MAX_BLOCKS; i++) begin
        if (rel_fire && (rel_slot == SW'(i))) occ[i] <= 1'b0;
        if (grant && (pick_slot == SW'(i))) begin
          occ[i]     <= 1'b1;
          thr_of[i]  <= TW'(req_threads);
          base_of[i] <= pick_base;
          size_of[i] <= AW'(need_w);
        end
      end

      resident_blocks  <= resident_blocks + BW'(grant) - BW'(rel_fire);
      resident_threads <= resident_threads + (grant ? TW'(req_threads) : '0)
                          - (rel_fire ? thr_of[rel_slot] : '0);
      used_regs        <= used_regs + (grant ? AW'(need_w) : '0)
                          - (rel_fire ? size_of[rel_slot] : '0);
    end
  end

  assign free_regs = AW'(REG_POOL) - used_regs;
endmodule

// File: rtl/blk_admit_chk.sv
module blk_admit_chk #(
  parameter int MAX_BLOCKS  = 8,
  parameter int MAX_THREADS = 768,
  parameter int REG_POOL    = 8192,
  parameter int BLK_THR_MAX = 512,
  parameter int RPT_W       = 8,
  localparam int SW   = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
  localparam int BW   = $clog2(MAX_BLOCKS + 1),
  localparam int TRW  = $clog2(BLK_THR_MAX) + 2,
  localparam int TW   = $clog2(MAX_THREADS + 1),
  localparam int AW   = $clog2(REG_POOL + 1)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic [TRW-1:0]                req_threads,
  input logic [RPT_W-1:0]              req_rpt,
  input logic [SW-1:0]                 rel_slot,
  input logic                          rel_fire,
  input logic                          resp_valid,
  input logic [1:0]                    resp_code,
  input logic [BW-1:0]                 resident_blocks,
  input logic [TW-1:0]                 resident_threads,
  input logic [AW-1:0]                 free_regs,
  input logic [MAX_BLOCKS-1:0]         occ,
  input logic [MAX_BLOCKS-1:0][AW-1:0] base_of,
  input logic [MAX_BLOCKS-1:0][AW-1:0] size_of
);
  // R9
  resp_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready));

  // R9
  fire_gives_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);

  // R5
  thread_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(resident_threads) <= MAX_THREADS);

  // R4
  block_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(resident_blocks) <= MAX_BLOCKS) && ($countones(occ) == 32'(resident_blocks)));

  // R2
  invalid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == 2'd2) |->
      $past(req_threads == '0 || 32'(req_threads) > BLK_THR_MAX || req_rpt == '0));

  // R8
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_fire |=> !occ[$past(rel_slot)]);

  // R6
  pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_regs) <= REG_POOL);

  logic overlap_any;
  always_comb begin
    overlap_any = 1'b0;
    for (int i = 0; i < MAX_BLOCKS; i++) begin
      if (occ[i] && (32'(base_of[i]) + 32'(size_of[i]) > REG_POOL)) overlap_any = 1'b1;
      for (int j = i + 1; j < MAX_BLOCKS; j++) begin
        if (occ[i] && occ[j] &&
            !((32'(base_of[i]) + 32'(size_of[i]) <= 32'(base_of[j])) ||
              (32'(base_of[j]) + 32'(size_of[j]) <= 32'(base_of[i]))))
          overlap_any = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      // R7
      disjoint_chk: assert (!overlap_any);
    end
  end
endmodule

bind blk_admit blk_admit_chk #(
  .MAX_BLOCKS (MAX_BLOCKS),
  .MAX_THREADS(MAX_THREADS),
  .REG_POOL   (REG_POOL),
  .BLK_THR_MAX(BLK_THR_MAX),
  .RPT_W      (RPT_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_threads     (req_threads),
  .req_rpt         (req_rpt),
  .rel_slot        (rel_slot),
  .rel_fire        (rel_fire),
  .resp_valid      (resp_valid),
  .resp_code       (resp_code),
  .resident_blocks (resident_blocks),
  .resident_threads(resident_threads),
  .free_regs       (free_regs),
  .occ             (occ),
  .base_of         (base_of),
  .size_of         (size_of)
);

// File: tb/blk_admit_tb.sv
`timescale 1ns/1ps
module blk_admit_tb;
  localparam int NB = 8, MT = 768, POOL = 8192, BTM = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [10:0] req_threads = '0;
  logic [7:0]  req_rpt = '0;
  logic        rel_valid = 1'b0;
  logic [2:0]  rel_slot = '0;
  logic        resp_valid;
  logic [1:0]  resp_code;
  logic [2:0]  resp_slot;
  logic [13:0] resp_base;
  logic [3:0]  resident_blocks;
  logic [9:0]  resident_threads;
  logic [13:0] free_regs;

  always #2 clk = ~clk;

  blk_admit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_rpt(req_rpt), .rel_valid(rel_valid),
    .rel_slot(rel_slot), .resp_valid(resp_valid), .resp_code(resp_code),
    .resp_slot(resp_slot), .resp_base(resp_base), .resident_blocks(resident_blocks),
    .resident_threads(resident_threads), .free_regs(free_regs)
  );

  int checks = 0, failures = 0;
  bit m_occ [NB];
  int m_thr [NB], m_base [NB], m_size [NB];
  int last_code, last_slot, last_base;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int m_blocks();
    int n = 0;
    for (int i = 0; i < NB; i++) n += int'(m_occ[i]);
    return n;
  endfunction

  function automatic int m_threads();
    int n = 0;
    for (int i = 0; i < NB; i++) if (m_occ[i]) n += m_thr[i];
    return n;
  endfunction

  function automatic int m_used();
    int n = 0;
    for (int i = 0; i < NB; i++) if (m_occ[i]) n += m_size[i];
    return n;
  endfunction

  // lowest gap of at least need entries: sort resident ranges, walk the holes
  function automatic int m_fit(int need);
    int sb [NB], ss [NB];
    int cnt = 0, pos = 0;
    for (int i = 0; i < NB; i++) if (m_occ[i]) begin
      sb[cnt] = m_base[i]; ss[cnt] = m_size[i]; cnt++;
    end
    for (int a = 1; a < cnt; a++)
      for (int b = a; b > 0 && sb[b-1] > sb[b]; b--) begin
        int tb = sb[b], ts = ss[b];
        sb[b] = sb[b-1]; ss[b] = ss[b-1]; sb[b-1] = tb; ss[b-1] = ts;
      end
    for (int k = 0; k < cnt; k++) begin
      if (sb[k] - pos >= need) return pos;
      pos = sb[k] + ss[k];
    end
    if (POOL - pos >= need) return pos;
    return -1;
  endfunction

  function automatic int m_lowest_free();
    for (int i = 0; i < NB; i++) if (!m_occ[i]) return i;
    return -1;
  endfunction

  task automatic counts(string req);
    chk(req, "resident_blocks", int'(resident_blocks), m_blocks());
    chk(req, "resident_threads", int'(resident_threads), m_threads());
    chk(req, "free_regs", int'(free_regs), POOL - m_used());
  endtask

  // one operation, starting and ending at a falling edge
  task automatic op(string req, bit rq, int thr, int rpt, bit rl, int rs);
    int e_code = 0, e_slot = 0, e_base = 0, need = 0, fb, fs;
    if (rq) begin
      need = thr * rpt;
      fs   = m_lowest_free();
      fb   = m_fit(need);
      if (thr < 1 || thr > BTM || rpt < 1) e_code = 2;
      else if (fs < 0 || m_threads() + thr > MT || fb < 0) e_code = 1;
      else begin e_code = 0; e_slot = fs; e_base = fb; end
    end
    req_valid   = rq;
    req_threads = 11'(thr);
    req_rpt     = 8'(rpt);
    rel_valid   = rl;
    rel_slot    = 3'(rs);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rel_valid = 1'b0;
    chk({req, "/R9"}, "resp_valid", int'(resp_valid), int'(rq));
    if (rq) begin
      chk(req, "resp_code", int'(resp_code), e_code);
      chk(req, "resp_slot", int'(resp_slot), e_slot);
      chk(req, "resp_base", int'(resp_base), e_base);
      last_code = int'(resp_code); last_slot = int'(resp_slot); last_base = int'(resp_base);
    end
    if (rl && m_occ[rs]) m_occ[rs] = 1'b0;
    if (rq && e_code == 0) begin
      m_occ[e_slot] = 1'b1; m_thr[e_slot] = thr; m_base[e_slot] = e_base; m_size[e_slot] = need;
    end
    counts(req);
  endtask

  task automatic free_all();
    for (int s = 0; s < NB; s++) op("R8", 1'b0, 0, 0, 1'b1, s);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "resp_valid in reset", int'(resp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready", int'(req_ready), 1);
    chk("R1", "resp_valid", int'(resp_valid), 0);
    counts("R1");

    // R2 invalid shapes
    op("R2", 1'b1, 0, 4, 1'b0, 0);
    chk("R2", "code zero threads", last_code, 2);
    op("R2", 1'b1, 513, 1, 1'b0, 0);
    chk("R2", "code 513 threads", last_code, 2);
    op("R2", 1'b1, 10, 0, 1'b0, 0);
    chk("R2", "code zero rpt", last_code, 2);

    // R3 plain accept
    op("R3", 1'b1, 64, 8, 1'b0, 0);
    chk("R3", "first slot", last_slot, 0);
    chk("R3", "first base", last_base, 0);
    op("R3", 1'b1, 512, 1, 1'b0, 0);
    chk("R3", "max-size block code", last_code, 0);
    chk("R3", "second base", last_base, 512);
    free_all();

    // R4 block limit, R10 request beside a release
    for (int i = 0; i < NB; i++) op("R4", 1'b1, 16, 4, 1'b0, 0);
    op("R4", 1'b1, 1, 1, 1'b0, 0);
    chk("R4", "ninth block code", last_code, 1);
    op("R10", 1'b1, 1, 1, 1'b1, 3);
    chk("R10", "full before release", last_code, 1);
    op("R10", 1'b1, 1, 1, 1'b0, 0);
    chk("R10", "freed slot reused", last_slot, 3);
    op("R8", 1'b0, 0, 0, 1'b1, 3);
    op("R8", 1'b0, 0, 0, 1'b1, 3);   // vacant slot: no effect
    free_all();

    // R5 thread limit
    op("R5", 1'b1, 512, 1, 1'b0, 0);
    op("R5", 1'b1, 256, 1, 1'b0, 0);
    op("R5", 1'b1, 1, 1, 1'b0, 0);
    chk("R5", "769th thread code", last_code, 1);
    free_all();

    // R6 registers, first fit and fragmentation; R8 merge
    op("R6", 1'b1, 256, 16, 1'b0, 0);
    op("R6", 1'b1, 256, 16, 1'b0, 0);
    chk("R6", "upper half base", last_base, 4096);
    op("R6", 1'b1, 1, 1, 1'b0, 0);
    chk("R6", "pool empty code", last_code, 1);
    op("R8", 1'b0, 0, 0, 1'b1, 0);
    op("R6", 1'b1, 128, 8, 1'b0, 0);
    op("R6", 1'b1, 128, 8, 1'b0, 0);
    chk("R6", "second quarter base", last_base, 1024);
    op("R6", 1'b1, 128, 16, 1'b0, 0);
    chk("R6", "third quarter base", last_base, 2048);
    op("R8", 1'b0, 0, 0, 1'b1, 0);
    op("R8", 1'b0, 0, 0, 1'b1, 2);
    op("R8", 1'b1, 256, 8, 1'b0, 0);
    chk("R8", "merged gap base", last_base, 0);
    op("R8", 1'b0, 0, 0, 1'b1, 0);
    op("R8", 1'b0, 0, 0, 1'b1, 1);
    op("R6", 1'b1, 96, 64, 1'b0, 0);
    chk("R6", "fragmented code", last_code, 1);
    op("R6", 1'b1, 64, 64, 1'b0, 0);
    chk("R6", "upper gap base", last_base, 4096);
    free_all();

    // R7 random mix; disjointness and placement follow the model
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom % 20);
      int thr = (r == 0) ? 0 : (r == 1) ? 513 + int'($urandom % 100) : 1 + int'($urandom % 300);
      int rpt = ($urandom % 25 == 0) ? 0 : 1 + int'($urandom % 20);
      op("R7", ($urandom % 4) != 0, thr, rpt, ($urandom % 3) == 0, int'($urandom % NB));
    end

    summary();
    $finish;
  end
endmodule